// File: doc/BRIEF.md
# Split-Word Adder/Subtractor with Speculative Upper Half

This block adds or subtracts two two's-complement words in a single combinational pass. The word is cut into a low part and a high part. The low part is a ripple chain of full adders, and it takes the incoming carry. The high part is built twice, side by side. One copy assumes an incoming carry of zero and the other assumes one. When the low chain settles, its carry-out picks one of the two high results.

Because of this, the high part never waits for a carry to travel the whole word. The slowest path is the low chain plus one multiplexer. For subtraction the second operand is inverted bit by bit, and the low chain's carry is forced to one, which adds A to the negation of B. The block reports the selected high carry. It also raises a signed-overflow flag when both operands entering the adder share a sign bit and the result's sign bit disagrees with it.

There are no states or transitions: the block has no clock and no storage. Every output is a pure function of the present inputs.

Top module: `csel_addsub`

## Requirements
- R1: With `sub_en`=0, `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^32.
- R2: With `sub_en`=1, `sum_out` equals (`op_a` − `op_b`) modulo 2^32, and `carry_in` has no effect on any output.
- R3: `carry_out` is bit 32 of the 33-bit sum `op_a` + B' + c', where B' = `op_b` and c' = `carry_in` when adding, and B' = ~`op_b` and c' = 1 when subtracting (so in subtraction 1 means no borrow).
- R4: `ovf_out` is 1 exactly when the signed result of the requested operation lies outside −2^31 .. 2^31−1. Equivalently, `op_a`[31] equals B'[31] and `sum_out`[31] differs from them. Otherwise it is 0.
- R5: A carry produced by the low 16 bits reaches the high 16 bits correctly, for example 0x0000FFFF + 1 = 0x00010000 with `carry_out`=0.
- R6: A carry that runs through the full word wraps the result: 0xFFFFFFFF + 1 gives 0, `carry_out`=1 and `ovf_out`=0.
- R7: Subtraction overflows at both ends of the range: 0x80000000 − 1 and 0 − 0x80000000 both set `ovf_out`.
- R8: The outputs are valid within the same time step as an input change. No clock or history is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, two's complement |
| op_b | input | 32 | Second operand, two's complement |
| sub_en | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b + carry_in |
| carry_in | input | 1 | Carry into bit 0 when adding; ignored when subtracting |
| sum_out | output | 32 | Result word |
| carry_out | output | 1 | Carry out of bit 31, taken from the selected high copy |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
The bench builds the block with its defaults: a 32-bit word split into two 16-bit halves. This puts the select point at bit 16, where a single carry out of bit 15 decides which speculative copy appears. Directed operands drive that boundary carry high and low, push carries through the whole word, and reach both signed range limits in add and subtract mode. A pseudo-random sweep then mixes carry patterns across both halves.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Default geometry of the split adder
    parameter int unsigned CSEL_WORD_W = 32;
    parameter int unsigned CSEL_LOW_W  = 16;

    // Operand after the add/subtract conditioning stage
    typedef struct packed {
        logic [CSEL_WORD_W-1:0] addend;
        logic                   cin;
    } csel_operand_t;

endpackage

// File: rtl/csel_half_add.sv
module csel_half_add (
    input  logic x_in,
    input  logic y_in,
    output logic s_out,
    output logic c_out
);
    assign s_out = x_in ^ y_in;
    assign c_out = x_in & y_in;
endmodule

// File: rtl/csel_full_add.sv
module csel_full_add (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic s_first;
    logic c_first;
    logic c_second;

    csel_half_add u_ha_first (
        .x_in  (x_in),
        .y_in  (y_in),
        .s_out (s_first),
        .c_out (c_first)
    );

    csel_half_add u_ha_second (
        .x_in  (s_first),
        .y_in  (c_in),
        .s_out (s_out),
        .c_out (c_second)
    );

    assign c_out = c_first | c_second;
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] s_out,
    output logic             c_out
);
    logic [WIDTH:0] chain;

    assign chain[0] = c_in;

    for (genvar bit_i = 0; bit_i < WIDTH; bit_i++) begin : g_stage
        csel_full_add u_fa (
            .x_in  (x_in[bit_i]),
            .y_in  (y_in[bit_i]),
            .c_in  (chain[bit_i]),
            .s_out (s_out[bit_i]),
            .c_out (chain[bit_i+1])
        );
    end

    assign c_out = chain[WIDTH];

    // The chain of full adders must agree with a plain arithmetic sum
    always_comb begin
        // R1
        ripple_sum_chk: assert ({c_out, s_out} ==
                                ({1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in}))
            else $error("ripple chain sum disagrees with arithmetic sum");
    end
endmodule

// File: rtl/csel_addsub.sv
module csel_addsub
    import csel_pkg::*;
#(
    parameter int unsigned WORD_W = CSEL_WORD_W,
    parameter int unsigned LOW_W  = CSEL_LOW_W
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_en,
    input  logic              carry_in,
    output logic [WORD_W-1:0] sum_out,
    output logic              carry_out,
    output logic              ovf_out
);
    localparam int unsigned HIGH_W = WORD_W - LOW_W;
    localparam int unsigned MSB    = WORD_W - 1;

    // Operand conditioning: invert B and force carry for subtraction
    logic [WORD_W-1:0] b_cond;
    logic              c_cond;

    always_comb begin
        b_cond = sub_en ? ~op_b : op_b;
        c_cond = sub_en ? 1'b1 : carry_in;
    end

    // Low half: real carry-in
    logic [LOW_W-1:0] low_sum;
    logic             low_carry;

    csel_ripple #(.WIDTH(LOW_W)) u_low (
        .x_in  (op_a[LOW_W-1:0]),
        .y_in  (b_cond[LOW_W-1:0]),
        .c_in  (c_cond),
        .s_out (low_sum),
        .c_out (low_carry)
    );

    // High half: two speculative copies with fixed carry-in
    logic [HIGH_W-1:0] high_sum_z;
    logic [HIGH_W-1:0] high_sum_o;
    logic              high_carry_z;
    logic              high_carry_o;

    csel_ripple #(.WIDTH(HIGH_W)) u_high_zero (
        .x_in  (op_a[MSB:LOW_W]),
        .y_in  (b_cond[MSB:LOW_W]),
        .c_in  (1'b0),
        .s_out (high_sum_z),
        .c_out (high_carry_z)
    );

    csel_ripple #(.WIDTH(HIGH_W)) u_high_one (
        .x_in  (op_a[MSB:LOW_W]),
        .y_in  (b_cond[MSB:LOW_W]),
        .c_in  (1'b1),
        .s_out (high_sum_o),
        .c_out (high_carry_o)
    );

    // Select stage driven by the low carry
    logic [HIGH_W-1:0] high_pick;
    logic              carry_pick;

    always_comb begin
        high_pick  = low_carry ? high_sum_o   : high_sum_z;
        carry_pick = low_carry ? high_carry_o : high_carry_z;
    end

    assign sum_out   = {high_pick, low_sum};
    assign carry_out = carry_pick;
    assign ovf_out   = (op_a[MSB] == b_cond[MSB]) && (sum_out[MSB] != op_a[MSB]);

    // Checks against independent arithmetic
    logic signed [WORD_W+1:0] exact_val;
    logic                     exact_out_of_range;

    always_comb begin
        exact_val = $signed({{2{op_a[MSB]}}, op_a}) + $signed({{2{b_cond[MSB]}}, b_cond})
                    + $signed({{(WORD_W+1){1'b0}}, c_cond});
        exact_out_of_range = (exact_val[WORD_W+1:MSB] != {3{exact_val[MSB]}});

        // R3
        word_sum_chk: assert ({carry_out, sum_out} ==
                              ({1'b0, op_a} + {1'b0, b_cond} + {{WORD_W{1'b0}}, c_cond}))
            else $error("selected word result disagrees with full-width sum");

        // R4
        no_overflow_chk: assert ((op_a[MSB] == b_cond[MSB]) || !ovf_out)
            else $error("overflow flagged for operands of opposite sign");

        // R4
        ovf_range_chk: assert (ovf_out == exact_out_of_range)
            else $error("overflow flag disagrees with signed range");

        // R5
        spec_pair_chk: assert ({high_carry_o, high_sum_o} ==
                               ({high_carry_z, high_sum_z} + {{HIGH_W{1'b0}}, 1'b1}))
            else $error("speculative high copies are not one apart");
    end
endmodule

// File: tb/csel_addsub_tb.sv
module csel_addsub_tb;
    localparam int W = 32;

    logic         clk;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         sub_en;
    logic         carry_in;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         ovf_out;

    int n_vec;
    int n_bad;
    bit done;

    csel_addsub u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .sub_en    (sub_en),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Apply one vector and compare all outputs with values computed here
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic ci, input string tag);
        logic [W-1:0] be;
        logic         ce;
        logic [W:0]   full;
        longint       ex;
        logic         ex_ovf;
        @(posedge clk);
        op_a = a; op_b = b; sub_en = s; carry_in = ci;
        @(negedge clk);
        be   = s ? ~b : b;
        ce   = s ? 1'b1 : ci;
        full = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, ce};
        if (s) ex = longint'($signed(a)) - longint'($signed(b));
        else   ex = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
        ex_ovf = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
        n_vec++;
        if (sum_out !== full[W-1:0]) begin
            n_bad++;
            $display("FAIL %s sum: actual %h expected %h", tag, sum_out, full[W-1:0]);
        end
        if (carry_out !== full[W]) begin
            n_bad++;
            $display("FAIL %s R3 carry: actual %b expected %b", tag, carry_out, full[W]);
        end
        if (ovf_out !== ex_ovf) begin
            n_bad++;
            $display("FAIL %s R4 ovf: actual %b expected %b", tag, ovf_out, ex_ovf);
        end
    endtask

    task automatic t_zero_state();
        apply(32'h0, 32'h0, 1'b0, 1'b0, "R1 all zero");
    endtask

    task automatic t_plain_add();
        apply(32'd7, 32'd6, 1'b0, 1'b0, "R1 small add");
        apply(32'h1234_5678, 32'h0FED_CBA9, 1'b0, 1'b1, "R1 add with carry_in");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b1, "R1 alternating bits");
    endtask

    task automatic t_subtract();
        apply(32'd7, 32'd6, 1'b1, 1'b0, "R2 small sub");
        apply(32'd6, 32'd7, 1'b1, 1'b0, "R2 sub borrow");
        apply(32'd6, 32'd7, 1'b1, 1'b1, "R2 carry_in ignored");
        apply(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, "R2 equal operands");
    endtask

    task automatic t_half_boundary();
        apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R5 low carry into high");
        apply(32'h0000_FFFF, 32'h0000_0000, 1'b0, 1'b1, "R5 carry_in into high");
        apply(32'h0000_7FFF, 32'h0000_0001, 1'b0, 1'b0, "R5 no low carry");
    endtask

    task automatic t_wrap();
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R6 full wrap");
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, "R6 wrap via carry_in");
    endtask

    task automatic t_overflow();
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R4 positive overflow");
        apply(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 negative overflow");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, "R4 mixed sign no ovf");
        apply(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, "R7 sub low end");
        apply(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, "R7 sub of min");
    endtask

    task automatic t_sweep();
        logic [W-1:0] st;
        logic [W-1:0] a;
        st = 32'h1D2C_3B4A;
        for (int k = 0; k < 300; k++) begin
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            a  = st;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            apply(a, st, st[3], st[9], "R8 sweep");
        end
    endtask

    initial begin
        n_vec = 0; n_bad = 0; done = 1'b0;
        op_a = '0; op_b = '0; sub_en = 1'b0; carry_in = 1'b0;
        t_zero_state();
        t_plain_add();
        t_subtract();
        t_half_boundary();
        t_wrap();
        t_overflow();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule